// File: doc/BRIEF.md
# RC5 Iterative Round Datapath (32-bit words, 12 rounds)

This block is the data engine of an RC5 block cipher using 32-bit words and 12 rounds. It works on a 64-bit block made of two words. Word A sits in bits 31:0 and word B in bits 63:32. A multiplexer picks either a freshly loaded block or the fed-back state. The choice goes into a single state register, and one round of combinational logic closes the loop. Each accepted step applies exactly one operation: key whitening, one full round, or key un-whitening. The same loop serves both directions.

An external controller issues `load_i` and `step_i`. The block publishes a key-pair index on `key_idx_o`. External round-key storage must answer in the same cycle with S[2·idx] on `key_a_i` and S[2·idx+1] on `key_b_i`. Key expansion is done outside the block.

A small internal sequencer has five states:
- IDLE: after reset.
- WHITEN: encryption pre-add.
- ROUND: one round per step.
- UNWHITEN: decryption post-subtract.
- DONE: result held.

Its transitions are:
- LOAD: from any state, to WHITEN when encrypting or to ROUND when decrypting.
- PRE_STEP: WHITEN → ROUND.
- NEXT_ROUND: ROUND → ROUND.
- LAST_ENC: ROUND → DONE, on round 12 of encryption.
- LAST_DEC: ROUND → UNWHITEN, on round 1 of decryption.
- POST_STEP: UNWHITEN → DONE.

Top module: `rc5_iter_core`

## Requirements
- R1: After reset, `blk_o` is 0, `busy_o` and `done_o` are 0, and `key_idx_o` is 0.
- R2: At a clock edge with `load_i`=1, in any state, the register takes `blk_i` with A = bits 31:0 and B = bits 63:32. The direction `dec_i` is captured (1 = decrypt, 0 = encrypt). Next, `busy_o`=1 and `done_o`=0. Load takes priority over `step_i` in the same cycle.
- R3: For encryption, `key_idx_o` is 0 after load. The first step adds `key_a_i` to A and `key_b_i` to B modulo 2^32. The index then runs 1, 2, … 12, one per step.
- R4: An encryption round with key pair i computes A = ((A xor B) rotated left by B[4:0]) + S[2i], then B = ((B xor new A) rotated left by new A[4:0]) + S[2i+1].
- R5: For decryption, `key_idx_o` is 12 after load and counts down by one per step to 1. After the round-1 step it reads 0, and the next step subtracts S[1] from B and S[0] from A.
- R6: A decryption round with key pair i computes B = ((B − S[2i+1]) rotated right by A[4:0]) xor A, then A = ((A − S[2i]) rotated right by new B[4:0]) xor new B.
- R7: Exactly 13 accepted steps after a load give `done_o`=1 and `busy_o`=0. In DONE, `blk_o` holds the result and further steps change nothing.
- R8: A cycle without `step_i` or `load_i` leaves `blk_o` and `key_idx_o` unchanged.
- R9: In IDLE, `step_i` is ignored: `blk_o` stays 0 and `busy_o` stays 0.
- R10: With an all-zero 16-byte key, encrypting block 0 yields 64'h6D8F4B15_EEDBA521. With key bytes 91 5F 46 19 BE 41 B2 51 63 55 A5 01 10 A9 CE 91, encrypting 64'h6D8F4B15_EEDBA521 yields 64'h52892B5B_AC13C0F7. Decryption restores every plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load `blk_i` and `dec_i`, start a run |
| dec_i | input | 1 | Direction at load: 1 decrypt, 0 encrypt |
| blk_i | input | 64 | Block to load, A in bits 31:0 |
| step_i | input | 1 | Apply one operation this cycle |
| key_idx_o | output | 4 | Key-pair index requested from key storage |
| key_a_i | input | 32 | S[2·key_idx_o] |
| key_b_i | input | 32 | S[2·key_idx_o+1] |
| blk_o | output | 64 | State register, B in bits 63:32 |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Result ready and held |

## Verification
The assertions check several control properties on every cycle:
- the loaded value appears in the register;
- the register holds still when no step arrives;
- the DONE result stays frozen;
- IDLE stays put;
- the encryption index advances from WHITEN to round 1;
- the decryption index counts down one per step.

The arithmetic of each round, and whether the full 13-step sequence matches published ciphertexts and inverts correctly, can only be shown by the bench. It runs a behavioural model against the outputs each cycle, over fixed vectors, random round trips and a load that interrupts a run.

// File: rtl/rc5_iter_pkg.sv
package rc5_iter_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WHITEN,
        ST_ROUND,
        ST_UNWHITEN,
        ST_DONE
    } rc5_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADDKEY,
        OP_ENCRND,
        OP_DECRND,
        OP_SUBKEY
    } rc5_op_e;
endpackage

// File: rtl/rc5_round_logic.sv
module rc5_round_logic
    import rc5_iter_pkg::*;
#(
    parameter int W = 32
) (
    input  rc5_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [W-1:0]   ka_i,
    input  logic [W-1:0]   kb_i,
    output logic [W-1:0]   a_o,
    output logic [W-1:0]   b_o
);
    localparam int SH_W = $clog2(W);

    function automatic logic [W-1:0] rotl(logic [W-1:0] x, logic [SH_W-1:0] s);
        logic [2*W-1:0] t;
        t = {x, x} << s;
        return t[2*W-1:W];
    endfunction

    function automatic logic [W-1:0] rotr(logic [W-1:0] x, logic [SH_W-1:0] s);
        logic [2*W-1:0] t;
        t = {x, x} >> s;
        return t[W-1:0];
    endfunction

    logic [W-1:0] enc_a, enc_b, dec_a, dec_b;

    // forward half-rounds: A first, then B using the new A
    assign enc_a = rotl(a_i ^ b_i, b_i[SH_W-1:0]) + ka_i;
    assign enc_b = rotl(b_i ^ enc_a, enc_a[SH_W-1:0]) + kb_i;
    // inverse half-rounds: B first, then A using the new B
    assign dec_b = rotr(b_i - kb_i, a_i[SH_W-1:0]) ^ a_i;
    assign dec_a = rotr(a_i - ka_i, dec_b[SH_W-1:0]) ^ dec_b;

    always_comb begin
        unique case (op_i)
            OP_ADDKEY: begin a_o = a_i + ka_i; b_o = b_i + kb_i; end
            OP_ENCRND: begin a_o = enc_a;      b_o = enc_b;      end
            OP_DECRND: begin a_o = dec_a;      b_o = dec_b;      end
            OP_SUBKEY: begin a_o = a_i - ka_i; b_o = b_i - kb_i; end
            default:   begin a_o = a_i;        b_o = b_i;        end
        endcase
    end
endmodule

// File: rtl/rc5_iter_ctrl.sv
module rc5_iter_ctrl
    import rc5_iter_pkg::*;
#(
    parameter int ROUNDS = 12,
    parameter int IDX_W  = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic             step_i,
    output rc5_op_e          op_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS);
    localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

    rc5_state_e       st_q, st_n;
    logic [IDX_W-1:0] rnd_q, rnd_n;
    logic             dec_q, dec_n;

    always_comb begin
        st_n  = st_q;
        rnd_n = rnd_q;
        dec_n = dec_q;
        if (load_i) begin
            dec_n = dec_i;
            st_n  = dec_i ? ST_ROUND : ST_WHITEN;
            rnd_n = dec_i ? LAST : '0;
        end else if (step_i) begin
            unique case (st_q)
                ST_IDLE, ST_DONE: ;
                ST_WHITEN: begin st_n = ST_ROUND; rnd_n = ONE; end
                ST_ROUND: begin
                    if (!dec_q) begin
                        if (rnd_q == LAST) st_n = ST_DONE;
                        else               rnd_n = rnd_q + ONE;
                    end else begin
                        if (rnd_q == ONE) begin st_n = ST_UNWHITEN; rnd_n = '0; end
                        else                    rnd_n = rnd_q - ONE;
                    end
                end
                ST_UNWHITEN: st_n = ST_DONE;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rnd_q <= '0;
            dec_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            rnd_q <= rnd_n;
            dec_q <= dec_n;
        end
    end

    always_comb begin
        op_o   = OP_NONE;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (st_q)
            ST_IDLE:     ;
            ST_WHITEN:   begin busy_o = 1'b1; if (step_i && !load_i) op_o = OP_ADDKEY; end
            ST_ROUND:    begin busy_o = 1'b1;
                               if (step_i && !load_i) op_o = dec_q ? OP_DECRND : OP_ENCRND; end
            ST_UNWHITEN: begin busy_o = 1'b1; if (step_i && !load_i) op_o = OP_SUBKEY; end
            ST_DONE:     done_o = 1'b1;
            default:     ;
        endcase
    end

    assign idx_o = rnd_q;

    // R9: a step never wakes the sequencer from IDLE
    a_r9_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !load_i) |=> (st_q == ST_IDLE));
    // R3: the pre-add step hands over to round 1
    a_r3_first_round: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WHITEN && step_i && !load_i) |=> (st_q == ST_ROUND && rnd_q == ONE));
    // R5: decryption index counts down by one per step
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ROUND && dec_q && step_i && !load_i && rnd_q > ONE)
        |=> (rnd_q == $past(rnd_q) - ONE));
endmodule

// File: rtl/rc5_iter_core.sv
module rc5_iter_core
    import rc5_iter_pkg::*;
#(
    parameter int W      = 32,
    parameter int ROUNDS = 12,
    parameter int IDX_W  = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [2*W-1:0]   blk_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] key_idx_o,
    input  logic [W-1:0]     key_a_i,
    input  logic [W-1:0]     key_b_i,
    output logic [2*W-1:0]   blk_o,
    output logic             busy_o,
    output logic             done_o
);
    rc5_op_e        op;
    logic [2*W-1:0] data_q, data_n;
    logic [W-1:0]   a_nx, b_nx;

    rc5_iter_ctrl #(.ROUNDS(ROUNDS), .IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .dec_i(dec_i),
        .step_i(step_i), .op_o(op), .idx_o(key_idx_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    rc5_round_logic #(.W(W)) round_i (
        .op_i(op), .a_i(data_q[W-1:0]), .b_i(data_q[2*W-1:W]),
        .ka_i(key_a_i), .kb_i(key_b_i), .a_o(a_nx), .b_o(b_nx)
    );

    // input multiplexer: fresh block or fed-back round result
    assign data_n = load_i ? blk_i : {b_nx, a_nx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_n;
    end

    assign blk_o = data_q;

    // R2: a load lands in the register and marks the run busy
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (busy_o && !done_o && data_q == $past(blk_i)));
    // R8: no step and no load keeps the state still
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(data_q) && $stable(key_idx_o)));
    // R7: a finished result stays frozen until the next load
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o && $stable(data_q)));
endmodule

// File: tb/rc5_iter_core_tb_top.sv
module rc5_iter_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, dec_i = 1'b0, step_i = 1'b0;
    logic [63:0] blk_i = '0;
    logic [3:0]  key_idx_o;
    logic [31:0] key_a_i, key_b_i;
    logic [63:0] blk_o;
    logic        busy_o, done_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [31:0] S [26];

    always #4 clk = ~clk;  // 125 MHz

    rc5_iter_core dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .dec_i(dec_i), .blk_i(blk_i),
        .step_i(step_i), .key_idx_o(key_idx_o), .key_a_i(key_a_i), .key_b_i(key_b_i),
        .blk_o(blk_o), .busy_o(busy_o), .done_o(done_o)
    );

    // external key storage, answered in the same cycle
    always_comb begin
        key_a_i = S[int'(key_idx_o) * 2];
        key_b_i = S[int'(key_idx_o) * 2 + 1];
    end

    function automatic logic [31:0] brol(logic [31:0] x, int s);
        s = s % 32;
        if (s == 0) return x;
        return (x << s) | (x >> (32 - s));
    endfunction
    function automatic logic [31:0] bror(logic [31:0] x, int s);
        s = s % 32;
        if (s == 0) return x;
        return (x >> s) | (x << (32 - s));
    endfunction

    // key expansion; byte 0 of the key is key[127:120]
    task automatic expand(input logic [127:0] key);
        logic [31:0] L [4];
        logic [31:0] x, y;
        int i, j;
        for (int k = 0; k < 4; k++)
            for (int m = 0; m < 4; m++)
                L[k][8*m +: 8] = key[127 - 8*(4*k + m) -: 8];
        S[0] = 32'hB7E15163;
        for (int k = 1; k < 26; k++) S[k] = S[k-1] + 32'h9E3779B9;
        x = 0; y = 0; i = 0; j = 0;
        for (int k = 0; k < 78; k++) begin
            S[i] = brol(S[i] + x + y, 3);  x = S[i];
            L[j] = brol(L[j] + x + y, int'(x + y) & 31); y = L[j];
            i = (i + 1) % 26; j = (j + 1) % 4;
        end
    endtask

    // behavioural reference: phase 0 idle, 1 pre-add, 2 rounds, 3 post-sub, 4 done
    int          m_phase = 0, m_rnd = 0;
    bit          m_dec = 0;
    logic [31:0] m_a = 0, m_b = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rnd = 0; m_dec = 0; m_a = 0; m_b = 0;
        end else if (load_i) begin
            m_a = blk_i[31:0]; m_b = blk_i[63:32]; m_dec = dec_i;
            m_phase = dec_i ? 2 : 1; m_rnd = dec_i ? 12 : 0;
        end else if (step_i) begin
            case (m_phase)
                1: begin m_a += S[0]; m_b += S[1]; m_phase = 2; m_rnd = 1; end
                2: if (!m_dec) begin
                       m_a = brol(m_a ^ m_b, int'(m_b[4:0])) + S[2*m_rnd];
                       m_b = brol(m_b ^ m_a, int'(m_a[4:0])) + S[2*m_rnd+1];
                       if (m_rnd == 12) m_phase = 4; else m_rnd++;
                   end else begin
                       m_b = bror(m_b - S[2*m_rnd+1], int'(m_a[4:0])) ^ m_a;
                       m_a = bror(m_a - S[2*m_rnd], int'(m_b[4:0])) ^ m_b;
                       if (m_rnd == 1) begin m_phase = 3; m_rnd = 0; end else m_rnd--;
                   end
                3: begin m_b -= S[1]; m_a -= S[0]; m_phase = 4; end
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model (R3, R4, R5, R6, R8)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [69:0] act, exp;
            act = {blk_o, key_idx_o, busy_o, done_o};
            exp = {m_b, m_a, 4'(m_rnd), (m_phase >= 1 && m_phase <= 3), (m_phase == 4)};
            n_chk++;
            if (act !== exp) begin
                n_bad++;
                $display("FAIL R3/R4/R5/R6/R8 cycle model: actual %h expected %h", act, exp);
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_load(logic [63:0] b, logic d, logic with_step);
        @(negedge clk); load_i = 1; blk_i = b; dec_i = d; step_i = with_step;
        @(negedge clk); load_i = 0; step_i = 0;
    endtask
    task automatic burst(int n);
        @(negedge clk); step_i = 1;
        repeat (n) @(negedge clk);
        step_i = 0;
    endtask
    task automatic pulse;
        burst(1);
    endtask

    task automatic run(logic [63:0] b, logic d, output logic [63:0] r);
        do_load(b, d, 0);
        burst(13);
        r = blk_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, ct;
        logic [63:0] hold;
        expand('0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset blk", blk_o, 64'h0);
        chk("R1 reset flags/idx", {busy_o, done_o, key_idx_o}, 6'h0);

        pulse;
        chk("R9 step in idle", {blk_o, busy_o}, 65'h0);

        // encryption with zero key, step by step
        do_load(64'h0, 0, 0);
        chk("R2 loaded block", blk_o, 64'h0);
        chk("R3 index after load", {busy_o, done_o, key_idx_o}, {1'b1, 1'b0, 4'd0});
        pulse;
        chk("R3 pre-add result", blk_o, {S[1], S[0]});
        chk("R3 index moves to 1", key_idx_o, 4'd1);
        hold = blk_o;
        repeat (3) @(negedge clk);
        chk("R8 hold without step", blk_o, hold);
        pulse;
        chk("R4 round 1 result", blk_o, {brol(S[1] ^ (brol(S[0] ^ S[1], int'(S[1][4:0])) + S[2]),
             int'((brol(S[0] ^ S[1], int'(S[1][4:0])) + S[2]) & 31)) + S[3],
             brol(S[0] ^ S[1], int'(S[1][4:0])) + S[2]});
        burst(11);
        chk("R7 done after 13 steps", {busy_o, done_o}, 2'b01);
        chk("R10 zero-key ciphertext", blk_o, 64'h6D8F4B15_EEDBA521);
        ct = blk_o;
        burst(3);
        chk("R7 steps ignored in done", blk_o, ct);

        // decryption of that ciphertext
        do_load(ct, 1, 0);
        chk("R5 index 12 after dec load", key_idx_o, 4'd12);
        burst(12);
        chk("R5 post-sub pending", {busy_o, done_o, key_idx_o}, {1'b1, 1'b0, 4'd0});
        pulse;
        chk("R6 decryption restores zero", blk_o, 64'h0);
        chk("R7 done after decrypt", {busy_o, done_o}, 2'b01);

        // second published vector
        @(negedge clk);
        expand(128'h915F4619_BE41B251_6355A501_10A9CE91);
        run(64'h6D8F4B15_EEDBA521, 0, r);
        chk("R10 second-key ciphertext", r, 64'h52892B5B_AC13C0F7);
        run(r, 1, r);
        chk("R10 second-key round trip", r, 64'h6D8F4B15_EEDBA521);

        // load in mid-run, together with a step
        do_load(64'h0123_4567_89AB_CDEF, 0, 0);
        burst(4);
        do_load(64'hFEDC_BA98_7654_3210, 1, 1);
        chk("R2 load wins over step", blk_o, 64'hFEDC_BA98_7654_3210);
        chk("R2 restart index", key_idx_o, 4'd12);

        // random round trips
        for (int k = 0; k < 20; k++) begin
            logic [63:0] pt;
            pt = {$urandom(), $urandom()};
            run(pt, 0, r);
            run(r, 1, r);
            chk("R6 random round trip", r, pt);
        end

        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule